// File: doc/BRIEF.md
# Four-Lane Squelch Controller

This block decides, lane by lane, when the outputs of a four-lane transceiver must be silenced. Each receive lane brings a loss-of-signal indication, and each transmit lane brings an input-loss indication from a detector outside the block. Both kinds of signal are asynchronous to the block clock. They pass through a synchronizer and are then combined with per-lane configuration bits. The results are registered receive-squelch, transmit-squelch and transmit-disable controls.

Every transmit lane also keeps a sticky loss flag. A management read clears the flags, and any flag that is set raises an interrupt request. Per lane, the configuration can turn receive squelch off, turn transmit squelch off, and choose whether a lost transmit input reduces the modulation (squelch) or shuts the transmitter off completely (disable). After reset, squelch is enabled in both directions and the transmit action is squelch.

Top module: `quad_squelch_ctrl`

## Requirements
- R1: Each loss input passes through a synchronizer with SYNC_STAGES flops. With the default of two, a change driven between clock edges shows on the lane outputs and flags after the third rising edge.
- R2: `rx_squelch[i]` is high exactly when the synchronized receive loss of lane i is high and `cfg_rx_dis[i]` was loaded as 0.
- R3: When the synchronized transmit loss of lane i is high and its transmit-squelch-disable bit is 0, the lane is forced off. Mode bit 0 forces `tx_squelch[i]`, mode bit 1 forces `tx_disable[i]`, and the two are never high together. Otherwise both are low.
- R4: A synchronized transmit loss sets `tx_flag[i]`, whatever the lane's disable and mode bits are.
- R5: A set `tx_flag[i]` stays set after the loss goes away, until a read.
- R6: A one-cycle `flag_rd` pulse clears every flag whose lane no longer shows a synchronized loss. A lane still in loss during the read keeps its flag, because setting wins over clearing.
- R7: `irq` is high exactly when at least one `tx_flag` bit is high, and it changes on the same edge as the flags.
- R8: The configuration bits load on a clock edge where `cfg_we` is high. Reset returns every lane to receive squelch enabled, transmit squelch enabled and mode squelch (all bits 0).
- R9: While `rst` is high, all controls, flags and `irq` are driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_los_in | input | LANES | Asynchronous receive loss-of-signal, one bit per lane |
| tx_loss_in | input | LANES | Asynchronous transmit input-loss, one bit per lane |
| cfg_we | input | 1 | Load strobe for the three configuration vectors |
| cfg_rx_dis | input | LANES | 1 turns receive squelch off for the lane |
| cfg_tx_dis | input | LANES | 1 turns transmit off-action off for the lane |
| cfg_tx_mode | input | LANES | Transmit off-action: 0 squelch, 1 disable |
| flag_rd | input | 1 | Read of the flag register; clears flags no longer in loss |
| rx_squelch | output | LANES | Receive output squelch control |
| tx_squelch | output | LANES | Transmit squelch control |
| tx_disable | output | LANES | Transmit disable control |
| tx_flag | output | LANES | Sticky transmit loss flags |
| irq | output | 1 | Interrupt request, OR of the flags |

## Verification
The read that clears the flags can land on the same edge as a synchronized transmit loss that sets a flag. The bench provokes this by setting flags on two lanes and then removing the loss from only one of them. It then issues a read while the other lane is still in loss. The flag of the lane still in loss must stay set and the other flag must clear, with `irq` still high. Sweeps over loss patterns and configuration vectors check the steady-state controls computed arithmetically for each lane.

// File: rtl/sqc_pkg.sv
package sqc_pkg;
  typedef struct packed {
    logic rx_dis;
    logic tx_dis;
    logic tx_mode;
  } lane_cfg_t;

  localparam lane_cfg_t CFG_RESET = '{rx_dis: 1'b0, tx_dis: 1'b0, tx_mode: 1'b0};
endpackage

// File: rtl/sqc_sync.sv
module sqc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) st[g] <= '0;
        else     st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) st[g] <= '0;
        else     st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];

  if (STAGES > 1) begin : g_chk
    // R1: the last stage carries the previous stage one edge later
    assert_sync_shift_R1: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (q == $past(st[STAGES-2])));
  end
endmodule

// File: rtl/sqc_lane.sv
module sqc_lane
  import sqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rx_los_s,
  input  logic      tx_loss_s,
  input  logic      cfg_we,
  input  lane_cfg_t cfg_d,
  input  logic      flag_rd,
  output logic      rx_sq,
  output logic      tx_sq,
  output logic      tx_dis,
  output logic      flag_q,
  output logic      flag_nxt
);
  lane_cfg_t cfg_q;
  logic      tx_off;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_RESET;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign tx_off   = tx_loss_s & ~cfg_q.tx_dis;
  assign flag_nxt = tx_loss_s | (flag_q & ~flag_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sq  <= 1'b0;
      tx_sq  <= 1'b0;
      tx_dis <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rx_sq  <= rx_los_s & ~cfg_q.rx_dis;
      tx_sq  <= tx_off & ~cfg_q.tx_mode;
      tx_dis <= tx_off & cfg_q.tx_mode;
      flag_q <= flag_nxt;
    end
  end

  assert_rx_on_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rx_los_s) && !$past(cfg_q.rx_dis)) |-> rx_sq);
  assert_rx_off_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rx_los_s)) |-> !rx_sq);
  assert_tx_excl_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_sq, tx_dis}));
  assert_tx_forced_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tx_loss_s) && !$past(cfg_q.tx_dis)) |-> (tx_sq || tx_dis));
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(tx_loss_s)) |-> flag_q);
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flag_q) && !$past(flag_rd)) |-> flag_q);
  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(flag_rd) && !$past(tx_loss_s)) |-> !flag_q);
endmodule

// File: rtl/quad_squelch_ctrl.sv
module quad_squelch_ctrl
  import sqc_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] rx_los_in,
  input  logic [LANES-1:0] tx_loss_in,
  input  logic             cfg_we,
  input  logic [LANES-1:0] cfg_rx_dis,
  input  logic [LANES-1:0] cfg_tx_dis,
  input  logic [LANES-1:0] cfg_tx_mode,
  input  logic             flag_rd,
  output logic [LANES-1:0] rx_squelch,
  output logic [LANES-1:0] tx_squelch,
  output logic [LANES-1:0] tx_disable,
  output logic [LANES-1:0] tx_flag,
  output logic             irq
);
  localparam int SW = 2 * LANES;

  logic [SW-1:0]    loss_s;
  logic [LANES-1:0] flag_nxt;

  sqc_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({tx_loss_in, rx_los_in}),
    .q   (loss_s)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_cfg_t cfg_d;
    assign cfg_d = '{rx_dis: cfg_rx_dis[i], tx_dis: cfg_tx_dis[i], tx_mode: cfg_tx_mode[i]};

    sqc_lane u_lane (
      .clk       (clk),
      .rst       (rst),
      .rx_los_s  (loss_s[i]),
      .tx_loss_s (loss_s[LANES+i]),
      .cfg_we    (cfg_we),
      .cfg_d     (cfg_d),
      .flag_rd   (flag_rd),
      .rx_sq     (rx_squelch[i]),
      .tx_sq     (tx_squelch[i]),
      .tx_dis    (tx_disable[i]),
      .flag_q    (tx_flag[i]),
      .flag_nxt  (flag_nxt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |flag_nxt;
  end

  assert_irq_any_R7: assert property (@(posedge clk) disable iff (rst)
    irq == (|tx_flag));
  assert_reset_quiet_R9: assert property (@(posedge clk)
    $past(rst) |-> (rx_squelch == '0 && tx_squelch == '0 && tx_disable == '0
                    && tx_flag == '0 && !irq));
endmodule

// File: tb/quad_squelch_ctrl_tb.sv
module quad_squelch_ctrl_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] rx_los_in = '0, tx_loss_in = '0;
  logic         cfg_we = 1'b0;
  logic [N-1:0] cfg_rx_dis = '0, cfg_tx_dis = '0, cfg_tx_mode = '0;
  logic         flag_rd = 1'b0;
  logic [N-1:0] rx_squelch, tx_squelch, tx_disable, tx_flag;
  logic         irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_squelch_ctrl #(.LANES(N), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .rx_los_in(rx_los_in), .tx_loss_in(tx_loss_in),
    .cfg_we(cfg_we), .cfg_rx_dis(cfg_rx_dis), .cfg_tx_dis(cfg_tx_dis),
    .cfg_tx_mode(cfg_tx_mode), .flag_rd(flag_rd), .rx_squelch(rx_squelch),
    .tx_squelch(tx_squelch), .tx_disable(tx_disable), .tx_flag(tx_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [N-1:0] rxd, input logic [N-1:0] txd, input logic [N-1:0] md);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rx_dis = rxd; cfg_tx_dis = txd; cfg_tx_mode = md;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // from a negedge where inputs changed: three rising edges, then sample at negedge
  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_flags();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 rst rx", rx_squelch, 0);
    chk("R9 rst txs", tx_squelch, 0);
    chk("R9 rst txd", tx_disable, 0);
    chk("R9 rst flag", tx_flag, 0);
    chk("R9 rst irq", irq, 0);
    rst = 1'b0;

    // R1: latency of three edges
    @(negedge clk);
    rx_los_in = 4'b1001;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 not yet", rx_squelch, 0);
    @(posedge clk); @(negedge clk);
    chk("R1 third edge", rx_squelch, 4'b1001);
    rx_los_in = '0;
    settle();

    // R2 sweep: receive loss x receive disable
    for (int d = 0; d < 16; d++) begin
      cfg_write(d[N-1:0], '0, '0);
      for (int l = 0; l < 16; l++) begin
        rx_los_in = l[N-1:0];
        settle();
        chk("R2 rx squelch", rx_squelch, l[N-1:0] & ~d[N-1:0]);
      end
    end
    rx_los_in = '0;

    // R3-R7 sweep: transmit loss x disable x mode
    for (int mi = 0; mi < 4; mi++) begin
      for (int d = 0; d < 16; d++) begin
        cfg_write('0, d[N-1:0], 4'(mi * 5));
        for (int l = 0; l < 16; l++) begin
          logic [N-1:0] off, md;
          md  = 4'(mi * 5);
          off = l[N-1:0] & ~d[N-1:0];
          tx_loss_in = l[N-1:0];
          settle();
          chk("R3 tx squelch", tx_squelch, off & ~md);
          chk("R3 tx disable", tx_disable, off & md);
          chk("R4 flag set", tx_flag, l[N-1:0]);
          chk("R7 irq set", irq, (l != 0));
          tx_loss_in = '0;
          settle();
          chk("R5 flag sticky", tx_flag, l[N-1:0]);
          chk("R3 tx released", tx_squelch | tx_disable, 0);
          read_flags();
          chk("R6 flag cleared", tx_flag, 0);
          chk("R7 irq cleared", irq, 0);
        end
      end
    end

    // R6 collision: read while lane 0 still in loss, lane 2 loss gone
    cfg_write('0, '0, '0);
    tx_loss_in = 4'b0101;
    settle();
    tx_loss_in = 4'b0001;
    settle();
    chk("R5 both flags held", tx_flag, 4'b0101);
    read_flags();
    chk("R6 set wins over clear", tx_flag, 4'b0001);
    chk("R7 irq held", irq, 1);
    tx_loss_in = '0;
    settle();
    read_flags();
    chk("R6 final clear", tx_flag, 0);

    // R8: reset restores defaults after configuration was changed
    cfg_write(4'hF, 4'hF, 4'hF);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rx_los_in = 4'hF; tx_loss_in = 4'hF;
    settle();
    chk("R8 rx default on", rx_squelch, 4'hF);
    chk("R8 tx default squelch", tx_squelch, 4'hF);
    chk("R8 tx no disable", tx_disable, 0);
    // R8: load without strobe has no effect
    @(negedge clk); cfg_rx_dis = 4'hF;
    settle();
    chk("R8 no load without we", rx_squelch, 4'hF);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule